// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Controller

This block picks the clock that drives the core and its peripherals. Two oscillators feed it: a fast internal one that is usable at once, and an external crystal or resonator that needs time to settle. When the external source is a crystal type, the block does not hold the core idle while the crystal settles. It runs the core from the internal clock and counts external oscillations in the background. When the count completes, it moves the core onto the external clock with a handover that cannot glitch. Software can also force the internal source through a select bit.

The block enters this start-up sequence at three points: after power-on reset, once the power-up timer reports expiry, and on every wake from sleep. Sleep stops the output clock and abandons any count in progress. The control and status pins are plain levels. No data stream passes through the block, so none of its pins carries a valid/ready handshake. The internal clock input arrives already divided to the wanted frequency.

Top module: `two_speed_clkctl`

## Requirements
- R1: While reset is asserted, and after it until `pwrt_expired` is high, `sys_clk` stays low and both `startup_done` and `src_ext` read 0.
- R2: In a crystal mode (`osc_mode` 000, 001 or 010), `startup_done` rises no earlier than OST_CYCLES (default 1024) external clock periods after the start-up sequence begins. It rises no later than that plus a few synchroniser cycles, and the count always restarts from zero.
- R3: With `two_speed_en`=1, the select bit at 0 and a crystal mode, `sys_clk` runs at the internal clock rate while the count proceeds, and `startup_done` stays 0.
- R4: When the count ends, the internal clock is gated off at one of its falling edges and `startup_done` is then set. When it rises, `sys_clk` is low and neither source is passing through.
- R5: `src_ext` reads 0 for internal and 1 for external. It changes only after `sys_clk` is already running from the new source, and after a completed start-up it rises after `startup_done` does. From then on `sys_clk` has the external period.
- R6: While `sleep_req` is high, `sys_clk` stops and `startup_done` is 0, and a count in progress is dropped. When `sleep_req` falls, the start-up sequence runs again from the internal clock.
- R7: A write of 1 to the select bit (`sel_wr` with `sel_wdata`=1) forces the internal source in any oscillator mode. This applies both when the block is already running on the external clock and before start-up. Writing 0 resumes the mode-driven choice.
- R8: Reset clears the select bit, and no automatic switch ever changes it.
- R9: For non-crystal modes (`osc_mode` 011 to 111), no count runs. `startup_done` and `src_ext` both reach 1 within a few clock cycles of `pwrt_expired`.
- R10: In a crystal mode with `two_speed_en`=0, `sys_clk` stays stopped for the whole count and then starts on the external clock.
- R11: `sys_clk` never glitches. Every high phase is a whole high phase of one source, no low phase is shorter than the shorter source half-period, and the two gates are never open together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock, already at the selected frequency; also clocks the sequencer |
| clk_ext | input | 1 | External oscillator clock; clocks the start-up counter |
| por_n | input | 1 | Asynchronous active-low reset |
| pwrt_expired | input | 1 | Power-up timer done (tie high when that timer is unused) |
| osc_mode | input | 3 | Oscillator mode: 000/001/010 crystal types, others need no start-up |
| two_speed_en | input | 1 | Run the core from the internal clock during the count |
| sel_wr | input | 1 | Write strobe for the source-select bit (internal clock domain) |
| sel_wdata | input | 1 | Value written: 1 forces internal, 0 follows the mode |
| sleep_req | input | 1 | High while the core sleeps; its falling edge is the wake event |
| sys_clk | output | 1 | Glitch-free gated system clock |
| startup_done | output | 1 | Set once the external clock has been counted stable and taken over |
| src_ext | output | 1 | Source actually driving `sys_clk`: 0 internal, 1 external |

## Verification
If the sequencer holds a wrong state, the status pins show it at once. `startup_done` and `src_ext` then move in the wrong order, too early, or not at all, and the scoreboard catches this on the next transition. A bad start-up counter shows in the time between the start event and `startup_done`, which is a window of about fifteen microseconds. A bad gate enable shows at `sys_clk` within one clock phase, as a short pulse, a wrong period, or a clock that keeps running during sleep or during a held count.

// File: rtl/tss_pkg.sv
`timescale 1ns/1ps
package tss_pkg;

  // crystal-type modes that need the start-up count
  localparam logic [2:0] MODE_XTAL_LO  = 3'b000;
  localparam logic [2:0] MODE_XTAL_STD = 3'b001;
  localparam logic [2:0] MODE_XTAL_HI  = 3'b010;

  typedef enum logic [3:0] {
    ST_WAIT_PWR,
    ST_DECIDE,
    ST_TWO,
    ST_HOLD,
    ST_PARK,
    ST_GO_EXT,
    ST_EXT,
    ST_GO_INT,
    ST_INT,
    ST_SLEEP
  } seq_state_e;

  function automatic logic needs_count(input logic [2:0] mode);
    return (mode == MODE_XTAL_LO) || (mode == MODE_XTAL_STD) || (mode == MODE_XTAL_HI);
  endfunction

endpackage

// File: rtl/tss_sync.sv
`timescale 1ns/1ps
module tss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff[0] <= 1'b0;
    else        ff[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff[i] <= 1'b0;
      else        ff[i] <= ff[i-1];
    end
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/tss_gate.sv
`timescale 1ns/1ps
module tss_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic en_q,
  output logic gclk
);
  // enable changes only while clk is low, so gclk keeps whole high phases
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;
  end

  assign gclk = clk & en_q;
endmodule

// File: rtl/tss_ext_side.sv
`timescale 1ns/1ps
module tss_ext_side #(
  parameter int OST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ext,
  input  logic rst_n,
  input  logic ost_run,
  input  logic ext_req,
  output logic ost_done,
  output logic ext_req_s
);
  localparam int CNT_W = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OST_CYCLES - 1);

  logic run_s;
  logic [CNT_W-1:0] cnt_q;

  tss_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk(clk_ext), .rst_n(rst_n), .d(ost_run), .q(run_s)
  );

  tss_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk_ext), .rst_n(rst_n), .d(ext_req), .q(ext_req_s)
  );

  // counts external rising edges; dropping run clears everything
  always_ff @(posedge clk_ext or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ost_done <= 1'b0;
    end else if (!run_s) begin
      cnt_q    <= '0;
      ost_done <= 1'b0;
    end else if (cnt_q == LAST) begin
      ost_done <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tss_seq.sv
`timescale 1ns/1ps
module tss_seq
  import tss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrt_expired,
  input  logic [2:0] osc_mode,
  input  logic       two_speed_en,
  input  logic       sel_int,
  input  logic       sleep_req,
  input  logic       ost_done_s,
  input  logic       ext_on_s,
  input  logic       int_on,
  output logic       int_req,
  output logic       ost_run,
  output logic       ext_req,
  output logic       startup_done,
  output logic       src_ext
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_PWR: if (pwrt_expired) state_d = ST_DECIDE;
      ST_DECIDE: begin
        if (sleep_req)                       state_d = ST_SLEEP;
        else if (!ost_done_s && !ext_on_s) begin
          if (sel_int)                       state_d = ST_GO_INT;
          else if (!needs_count(osc_mode))   state_d = ST_PARK;
          else if (two_speed_en)             state_d = ST_TWO;
          else                               state_d = ST_HOLD;
        end
      end
      ST_TWO: begin
        if (sleep_req)       state_d = ST_SLEEP;
        else if (sel_int)    state_d = ST_INT;
        else if (ost_done_s) state_d = ST_PARK;
      end
      ST_HOLD: begin
        if (sleep_req)       state_d = ST_SLEEP;
        else if (sel_int)    state_d = ST_GO_INT;
        else if (ost_done_s) state_d = ST_PARK;
      end
      ST_PARK: begin
        if (sleep_req)       state_d = ST_SLEEP;
        else if (!int_on)    state_d = ST_GO_EXT;
      end
      // no exit until the external gate is confirmed open
      ST_GO_EXT: if (ext_on_s) state_d = ST_EXT;
      ST_EXT: begin
        if (sleep_req)       state_d = ST_SLEEP;
        else if (sel_int)    state_d = ST_GO_INT;
      end
      ST_GO_INT: begin
        if (sleep_req)       state_d = ST_SLEEP;
        else if (int_on)     state_d = ST_INT;
      end
      ST_INT: begin
        if (sleep_req)       state_d = ST_SLEEP;
        else if (!sel_int)   state_d = ST_DECIDE;
      end
      ST_SLEEP: if (!sleep_req) state_d = ST_DECIDE;
      default: state_d = ST_WAIT_PWR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT_PWR;
    else        state_q <= state_d;
  end

  assign int_req = (state_q == ST_TWO) || (state_q == ST_GO_INT) || (state_q == ST_INT);
  assign ost_run = (state_q == ST_TWO) || (state_q == ST_HOLD);
  assign ext_req = (state_q == ST_GO_EXT) || (state_q == ST_EXT);

  // flag: set once the internal gate is seen closed after the count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startup_done <= 1'b0;
    end else begin
      unique case (state_q)
        ST_PARK:           if (!int_on) startup_done <= 1'b1;
        ST_GO_EXT, ST_EXT: startup_done <= startup_done;
        default:           startup_done <= 1'b0;
      endcase
    end
  end

  // source readback follows the gate that is actually open
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        src_ext <= 1'b0;
    else if (ext_on_s) src_ext <= 1'b1;
    else if (int_on)   src_ext <= 1'b0;
  end
endmodule

// File: rtl/two_speed_clkctl.sv
`timescale 1ns/1ps
module two_speed_clkctl #(
  parameter int OST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_int,
  input  logic       clk_ext,
  input  logic       por_n,
  input  logic       pwrt_expired,
  input  logic [2:0] osc_mode,
  input  logic       two_speed_en,
  input  logic       sel_wr,
  input  logic       sel_wdata,
  input  logic       sleep_req,
  output logic       sys_clk,
  output logic       startup_done,
  output logic       src_ext
);
  logic sel_int_q;
  logic int_req, ost_run, ext_req;
  logic ost_done_x, ext_req_x;
  logic ost_done_s, ext_on_s;
  logic int_en_q, ext_en_q;
  logic int_gclk, ext_gclk;
  logic int_en_d;

  // software select: only a write changes it, reset clears it
  always_ff @(posedge clk_int or negedge por_n) begin
    if (!por_n)      sel_int_q <= 1'b0;
    else if (sel_wr) sel_int_q <= sel_wdata;
  end

  tss_seq u_seq (
    .clk         (clk_int),
    .rst_n       (por_n),
    .pwrt_expired(pwrt_expired),
    .osc_mode    (osc_mode),
    .two_speed_en(two_speed_en),
    .sel_int     (sel_int_q),
    .sleep_req   (sleep_req),
    .ost_done_s  (ost_done_s),
    .ext_on_s    (ext_on_s),
    .int_on      (int_en_q),
    .int_req     (int_req),
    .ost_run     (ost_run),
    .ext_req     (ext_req),
    .startup_done(startup_done),
    .src_ext     (src_ext)
  );

  tss_ext_side #(.OST_CYCLES(OST_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk_ext  (clk_ext),
    .rst_n    (por_n),
    .ost_run  (ost_run),
    .ext_req  (ext_req),
    .ost_done (ost_done_x),
    .ext_req_s(ext_req_x)
  );

  tss_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(clk_int), .rst_n(por_n), .d(ost_done_x), .q(ost_done_s)
  );

  tss_sync #(.STAGES(SYNC_STAGES)) u_exton_sync (
    .clk(clk_int), .rst_n(por_n), .d(ext_en_q), .q(ext_on_s)
  );

  assign int_en_d = int_req & ~ext_on_s;

  tss_gate u_int_gate (
    .clk(clk_int), .rst_n(por_n), .en(int_en_d), .en_q(int_en_q), .gclk(int_gclk)
  );

  tss_gate u_ext_gate (
    .clk(clk_ext), .rst_n(por_n), .en(ext_req_x), .en_q(ext_en_q), .gclk(ext_gclk)
  );

  assign sys_clk = int_gclk | ext_gclk;
endmodule

// File: rtl/tss_checker.sv
`timescale 1ns/1ps
module tss_checker (
  input logic clk_int,
  input logic por_n,
  input logic sleep_req,
  input logic pwrt_expired,
  input logic int_on,
  input logic ext_on,
  input logic startup_done,
  input logic src_ext
);
  a_r1_idle_before_pwrt: assert property (@(posedge clk_int) disable iff (!por_n)
    !pwrt_expired |-> (!int_on && !ext_on && !startup_done && !src_ext));

  a_r4_parked_at_flag: assert property (@(posedge clk_int) disable iff (!por_n)
    $rose(startup_done) |-> (!int_on && !ext_on));

  a_r5_src_ext_running: assert property (@(posedge clk_int) disable iff (!por_n)
    $rose(src_ext) |-> ext_on);

  a_r5_src_int_running: assert property (@(posedge clk_int) disable iff (!por_n)
    $fell(src_ext) |-> int_on);

  a_r6_sleep_clears_flag: assert property (@(posedge clk_int) disable iff (!por_n)
    (sleep_req && $past(sleep_req) && $past(sleep_req, 2)) |-> !startup_done);

  a_r11_gates_exclusive: assert property (@(posedge clk_int) disable iff (!por_n)
    !(int_on && ext_on));
endmodule

bind two_speed_clkctl tss_checker u_chk (
  .clk_int     (clk_int),
  .por_n       (por_n),
  .sleep_req   (sleep_req),
  .pwrt_expired(pwrt_expired),
  .int_on      (int_en_q),
  .ext_on      (ext_en_q),
  .startup_done(startup_done),
  .src_ext     (src_ext)
);

// File: tb/two_speed_clkctl_tb.sv
`timescale 1ns/1ps
module two_speed_clkctl_tb;
  localparam real T_EXT = 14.0;
  localparam real OST_NS = 1024.0 * T_EXT;

  logic clk_int = 1'b0, clk_ext = 1'b0, por_n = 1'b0, pwrt_expired = 1'b0;
  logic [2:0] osc_mode = 3'b001;
  logic two_speed_en = 1'b1, sel_wr = 1'b0, sel_wdata = 1'b0, sleep_req = 1'b0;
  logic sys_clk, startup_done, src_ext;

  int total = 0, bad = 0, rise_n = 0, glitch_bad = 0;
  bit finished = 0;
  logic [1:0] exp_v[$];
  string exp_tag[$];
  logic [1:0] prev = 2'b00;
  realtime last_t = 0.0;

  two_speed_clkctl u_dut (
    .clk_int(clk_int), .clk_ext(clk_ext), .por_n(por_n), .pwrt_expired(pwrt_expired),
    .osc_mode(osc_mode), .two_speed_en(two_speed_en), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .sleep_req(sleep_req), .sys_clk(sys_clk), .startup_done(startup_done), .src_ext(src_ext)
  );

  always #2 clk_int = ~clk_int;
  initial begin
    #0.3;
    forever #7 clk_ext = ~clk_ext;
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [1:0] v, input string tag);
    exp_v.push_back(v);
    exp_tag.push_back(tag);
  endtask

  // scoreboard monitor on {startup_done, src_ext}
  always @(negedge clk_int) begin
    if (!por_n) prev = 2'b00;
    else if ({startup_done, src_ext} != prev) begin
      if (exp_v.size() == 0) chk(1'b0, "R5", "unexpected status change", {startup_done, src_ext}, prev);
      else begin
        logic [1:0] e;
        string t;
        e = exp_v.pop_front();
        t = exp_tag.pop_front();
        chk({startup_done, src_ext} == e, t, "status transition", {startup_done, src_ext}, e);
      end
      prev = {startup_done, src_ext};
    end
  end

  always @(posedge sys_clk) rise_n++;

  // R11 pulse-width monitor
  always @(sys_clk) begin
    if (por_n) begin
      realtime w;
      w = $realtime - last_t;
      if (!sys_clk) begin
        if (!((w > 1.99 && w < 2.01) || (w > 6.99 && w < 7.01))) glitch_bad++;
      end else if (w < 1.99) glitch_bad++;
    end
    last_t = $realtime;
  end

  task automatic rises_in(input int ns, output int n);
    int s;
    s = rise_n;
    #(ns);
    n = rise_n - s;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_int);
  endtask

  task automatic wait_flag(output realtime t);
    do @(negedge clk_int); while (!startup_done);
    t = $realtime;
  endtask

  task automatic wait_src(input logic v);
    do @(negedge clk_int); while (src_ext != v);
  endtask

  task automatic write_sel(input logic v);
    @(negedge clk_int);
    sel_wr = 1'b1;
    sel_wdata = v;
    @(negedge clk_int);
    sel_wr = 1'b0;
  endtask

  task automatic do_reset(input logic [2:0] mode, input logic ieso);
    @(negedge clk_int);
    por_n = 1'b0;
    cycles(1);
    pwrt_expired = 1'b0;
    osc_mode = mode;
    two_speed_en = ieso;
    cycles(4);
    por_n = 1'b1;
    cycles(4);
  endtask

  task automatic check_ost(input realtime t0, input realtime t1, input string req);
    longint d;
    d = longint'(t1 - t0);
    chk((t1 - t0) >= OST_NS && (t1 - t0) <= OST_NS + 200.0, req, "start-up duration ns", d, longint'(OST_NS));
  endtask

  task automatic check_ext_period();
    realtime a, b;
    @(posedge sys_clk); a = $realtime;
    @(posedge sys_clk); b = $realtime;
    chk((b - a) > 13.9 && (b - a) < 14.1, "R5", "external period ns", longint'(b - a), 14);
    @(negedge clk_int);
  endtask

  initial begin
    realtime t0, t1;
    int n;

    // A: crystal mode, two-speed enabled
    cycles(3);
    chk(sys_clk == 1'b0 && startup_done == 1'b0 && src_ext == 1'b0, "R1", "outputs in reset", {sys_clk, startup_done, src_ext}, 0);
    por_n = 1'b1;
    cycles(5);
    rises_in(40, n);
    chk(n == 0, "R1", "clock before power-up timer", n, 0);
    chk(startup_done == 1'b0 && src_ext == 1'b0, "R1", "status before power-up timer", {startup_done, src_ext}, 0);
    @(negedge clk_int);
    pwrt_expired = 1'b1;
    t0 = $realtime;
    push(2'b10, "R4");
    push(2'b11, "R5");
    cycles(200);
    rises_in(40, n);
    chk(n >= 9 && n <= 11, "R3", "internal-rate rises in 40ns", n, 10);
    chk(startup_done == 1'b0, "R3", "flag during count", startup_done, 0);
    wait_flag(t1);
    check_ost(t0, t1, "R2");
    #0.5;
    chk(sys_clk == 1'b0, "R4", "sys_clk parked low at flag", sys_clk, 0);
    wait_src(1'b1);
    check_ext_period();

    // B: sleep from external, wake, sleep mid-count, wake
    @(negedge clk_int);
    sleep_req = 1'b1;
    push(2'b01, "R6");
    cycles(30);
    rises_in(100, n);
    chk(n == 0, "R6", "clock rises while asleep", n, 0);
    @(negedge clk_int);
    sleep_req = 1'b0;
    push(2'b00, "R6");
    cycles(1000);
    sleep_req = 1'b1;
    cycles(300);
    chk(startup_done == 1'b0, "R6", "flag after mid-count sleep", startup_done, 0);
    rises_in(100, n);
    chk(n == 0, "R6", "clock rises in mid-count sleep", n, 0);
    @(negedge clk_int);
    sleep_req = 1'b0;
    t0 = $realtime;
    push(2'b10, "R6");
    push(2'b11, "R6");
    wait_flag(t1);
    check_ost(t0, t1, "R6");
    wait_src(1'b1);

    // C: software forces internal from external
    push(2'b01, "R7");
    push(2'b00, "R7");
    write_sel(1'b1);
    wait_src(1'b0);
    cycles(4);
    rises_in(40, n);
    chk(n >= 9 && n <= 11, "R7", "internal-rate rises after select", n, 10);
    chk(startup_done == 1'b0, "R7", "flag with internal forced", startup_done, 0);

    // C2: reset clears select; non-crystal mode bypasses count
    do_reset(3'b100, 1'b1);
    @(negedge clk_int);
    pwrt_expired = 1'b1;
    push(2'b10, "R9");
    push(2'b11, "R8");
    cycles(100);
    chk(src_ext == 1'b1, "R8", "external chosen after reset", src_ext, 1);
    chk(startup_done == 1'b1, "R9", "flag without count", startup_done, 1);

    // D: crystal mode, two-speed disabled
    do_reset(3'b010, 1'b0);
    @(negedge clk_int);
    pwrt_expired = 1'b1;
    t0 = $realtime;
    push(2'b10, "R10");
    push(2'b11, "R10");
    cycles(500);
    rises_in(40, n);
    chk(n == 0, "R10", "clock during held count", n, 0);
    wait_flag(t1);
    check_ost(t0, t1, "R2");
    wait_src(1'b1);
    check_ext_period();

    // E: select written before power-up, then released
    do_reset(3'b000, 1'b1);
    write_sel(1'b1);
    @(negedge clk_int);
    pwrt_expired = 1'b1;
    cycles(5000);
    chk(startup_done == 1'b0 && src_ext == 1'b0, "R7", "crystal mode with internal forced", {startup_done, src_ext}, 0);
    rises_in(40, n);
    chk(n >= 9 && n <= 11, "R7", "internal rate before release", n, 10);
    push(2'b10, "R3");
    push(2'b11, "R3");
    write_sel(1'b0);
    t0 = $realtime;
    wait_flag(t1);
    check_ost(t0, t1, "R3");
    wait_src(1'b1);
    cycles(10);

    chk(exp_v.size() == 0, "R5", "expected transitions left", exp_v.size(), 0);
    chk(glitch_bad == 0, "R11", "bad sys_clk pulse widths", glitch_bad, 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_int);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule